// File: doc/BRIEF.md
# Paged Multi-Port I/O Register File

This block is the byte-wide register front end of a 48-line general-purpose I/O chip. A host issues single-cycle read and write strobes against a 16-byte address window. Six 8-bit port registers drive open-drain style pins: a 1 in a port bit pulls the matching line low, and a 0 releases it so that it floats high and can serve as an input. Reading a port returns the inverted pin levels, so a line held low reads back as 1.

A combined page/lock register selects which bank the three paged offsets reach, and it can freeze any port against writes. The paged offsets lead to an attached interrupt bank that holds the polarity, enable and interrupt-ID registers. The block does not store those registers. It forwards each paged access to the bank as a one-cycle select pulse that carries the page, the register index and the write data. The bank's pending summary comes back in as an input and is readable at its own offset.

Read data is registered. A read strobe in one cycle yields the byte on `rdData` after the next rising clock edge, and that byte is held until the next read.

Top module: `gpio_paged_regfile`

## Requirements
- R1: During and directly after the asynchronous reset, all port registers are zero (no line pulled low), page 0 is selected, no port is locked, `rdData` is zero and no bank strobe is asserted.
- R2: A write to offset k (0 to 5) of an unlocked port loads `wrData` into port k, and `pinDriveLow[8k+b]` equals bit b of that port from the next cycle on.
- R3: A read of offset k (0 to 5) returns the bitwise inverse of `pinLevel[8k+7:8k]` sampled in the strobe cycle, on `rdData` one cycle later.
- R4: Offset 0x7 is the page/lock register: bits 7:6 select the page and bit j (j = 0 to 5) locks port j. It is write-only and reads as zero.
- R5: A write to a locked port leaves that port unchanged, and a read of a locked port still returns its inverted pin levels.
- R6: Offset 0x6 reads the pending summary `intPend` in bits 2:0, with bits 7:3 zero. Writes to it change nothing.
- R7: On pages 1, 2 and 3, a write to offsets 0x8, 0x9 or 0xA asserts `bankWr` in the same cycle, with `bankIdx` = offset minus 8, `bankPage` = the current page and `bankWrData` = `wrData`. Page 1 is polarity, page 2 is enable and page 3 is interrupt ID.
- R8: On page 0, accesses to offsets 0x8 to 0xA assert no bank strobe, read as zero and change no port.
- R9: Paged reads on pages 1 and 2 return zero without `bankRd`. On page 3 they assert `bankRd` in the same cycle and return `bankRdData` one cycle later.
- R10: Offsets 0xB to 0xF read as zero, and writes to them change nothing.
- R11: `rdData` holds its last value in every cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte offset in the window |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| pinLevel | input | 48 | Sensed line levels, 8 per port |
| pinDriveLow | output | 48 | 1 pulls the matching line low |
| intPend | input | 3 | Pending summary from the interrupt bank |
| bankWr | output | 1 | Paged write select to the interrupt bank |
| bankRd | output | 1 | Paged read select to the interrupt bank |
| bankPage | output | 2 | Current page presented to the bank |
| bankIdx | output | 2 | Paged register index, offset minus 8 |
| bankWrData | output | 8 | Write data presented to the bank |
| bankRdData | input | 8 | Read data returned by the bank |

## Verification
The bench sets a lock on a port and then writes to it. A design that tested the lock in the wrong bit position, or not at all, would overwrite the port, and the pins would change. The bench sweeps the paged offsets on every page. A design that decoded the page wrongly would strobe the bank on page 0, or read the bank on the write-only pages, and garbage would appear on `rdData`. Reads of the ports, of the write-only page/lock register and of the unused top offsets are compared against pin levels that change between accesses. A missing inversion, a wrong byte lane or a read that is not forced to zero shows up as a wrong byte one cycle after the strobe. Idle cycles between reads catch a read register that reloads without a strobe.

// File: rtl/gpioPkg.sv
package gpioPkg;
  localparam int unsigned PORT_COUNT  = 6;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned ADDR_W      = 4;
  localparam int unsigned PAGE_W      = 2;
  localparam int unsigned PAGED_COUNT = 3;
  localparam int unsigned PIN_W       = PORT_COUNT * BYTE_W;
  localparam int unsigned PORT_SEL_W  = $clog2(PORT_COUNT);
  localparam int unsigned IDX_W       = $clog2(PAGED_COUNT);

  // offsets whose position the behaviour depends on
  localparam int unsigned PEND_OFS   = PORT_COUNT;
  localparam int unsigned CTRL_OFS   = PORT_COUNT + 1;
  localparam int unsigned PAGED_BASE = PORT_COUNT + 2;

  // page numbers
  localparam int unsigned PG_NONE = 0;
  localparam int unsigned PG_POL  = 1;
  localparam int unsigned PG_ENAB = 2;
  localparam int unsigned PG_ID   = 3;

  typedef enum logic [1:0] {
    SRC_ZERO,
    SRC_PORT,
    SRC_PEND,
    SRC_BANK
  } rdSrc_e;

  typedef struct packed {
    logic [PORT_COUNT-1:0] portWe;
    logic                  ctrlWe;
    logic                  rdLoad;
    rdSrc_e                rdSrc;
    logic [PORT_SEL_W-1:0] portSel;
  } strobes_t;
endpackage

// File: rtl/gpioCtrlDecode.sv
module gpioCtrlDecode
  import gpioPkg::*;
#(
  parameter int unsigned NPORT  = PORT_COUNT,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned PW     = PAGE_W,
  parameter int unsigned NPAGED = PAGED_COUNT
) (
  input  logic [AW-1:0]    addr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [PW-1:0]    curPage,
  input  logic [NPORT-1:0] lockMask,
  output strobes_t         stb,
  output logic             bankWr,
  output logic             bankRd,
  output logic [IDX_W-1:0] bankIdx
);
  localparam int unsigned PEND_A  = NPORT;
  localparam int unsigned CTRL_A  = NPORT + 1;
  localparam int unsigned PBASE_A = NPORT + 2;
  localparam int unsigned PLAST_A = PBASE_A + NPAGED - 1;

  logic isPort;
  logic isPaged;
  logic pageOn;

  always_comb begin
    isPort  = int'(addr) < NPORT;
    isPaged = (int'(addr) >= PBASE_A) && (int'(addr) <= PLAST_A);
    pageOn  = curPage != PW'(PG_NONE);
  end

  // one write enable per port, gated by that port's lock bit
  for (genvar k = 0; k < NPORT; k++) begin : g_portWe
    assign stb.portWe[k] = wrEn && (int'(addr) == k) && !lockMask[k];
  end

  assign stb.ctrlWe  = wrEn && (int'(addr) == CTRL_A);
  assign stb.rdLoad  = rdEn;
  assign stb.portSel = PORT_SEL_W'(addr);

  assign bankWr  = wrEn && isPaged && pageOn;
  assign bankRd  = rdEn && isPaged && (curPage == PW'(PG_ID));
  assign bankIdx = IDX_W'(addr - AW'(PBASE_A));

  always_comb begin
    if (isPort)                      stb.rdSrc = SRC_PORT;
    else if (int'(addr) == PEND_A)   stb.rdSrc = SRC_PEND;
    else if (bankRd)                 stb.rdSrc = SRC_BANK;
    else                             stb.rdSrc = SRC_ZERO;
  end
endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPkg::*;
#(
  parameter int unsigned NPORT  = PORT_COUNT,
  parameter int unsigned BW     = BYTE_W,
  parameter int unsigned PW     = PAGE_W,
  parameter int unsigned NPAGED = PAGED_COUNT
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [BW-1:0]       wrData,
  input  logic [NPORT*BW-1:0] pinLevel,
  input  logic [NPAGED-1:0]   intPend,
  input  logic [BW-1:0]       bankRdData,
  output logic [NPORT*BW-1:0] pinDriveLow,
  output logic [PW-1:0]       curPage,
  output logic [NPORT-1:0]    lockMask,
  output logic [BW-1:0]       rdData
);
  localparam int unsigned PAGE_LSB = BW - PW;

  logic [BW-1:0] portQ [NPORT];
  logic [PW-1:0] pageQ;
  logic [NPORT-1:0] lockQ;
  logic [BW-1:0] rdNext;
  logic [BW-1:0] portView;

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              portQ[k] <= '0;
      else if (stb.portWe[k]) portQ[k] <= wrData;
    end
    assign pinDriveLow[k*BW +: BW] = portQ[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageQ <= '0;
      lockQ <= '0;
    end else if (stb.ctrlWe) begin
      pageQ <= wrData[PAGE_LSB +: PW];
      lockQ <= wrData[NPORT-1:0];
    end
  end

  assign curPage  = pageQ;
  assign lockMask = lockQ;

  // lines held low read back as 1
  assign portView = ~pinLevel[int'(stb.portSel)*BW +: BW];

  always_comb begin
    unique case (stb.rdSrc)
      SRC_PORT: rdNext = portView;
      SRC_PEND: rdNext = {{(BW-NPAGED){1'b0}}, intPend};
      SRC_BANK: rdNext = bankRdData;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (stb.rdLoad) rdData <= rdNext;
  end
endmodule

// File: rtl/gpio_paged_regfile.sv
module gpio_paged_regfile
  import gpioPkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [BYTE_W-1:0]      wrData,
  output logic [BYTE_W-1:0]      rdData,
  input  logic [PIN_W-1:0]       pinLevel,
  output logic [PIN_W-1:0]       pinDriveLow,
  input  logic [PAGED_COUNT-1:0] intPend,
  output logic                   bankWr,
  output logic                   bankRd,
  output logic [PAGE_W-1:0]      bankPage,
  output logic [IDX_W-1:0]       bankIdx,
  output logic [BYTE_W-1:0]      bankWrData,
  input  logic [BYTE_W-1:0]      bankRdData
);
  strobes_t stb;
  logic [PAGE_W-1:0] curPage;
  logic [PORT_COUNT-1:0] lockMask;

  gpioCtrlDecode i_ctrl (
    .addr     (addr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .curPage  (curPage),
    .lockMask (lockMask),
    .stb      (stb),
    .bankWr   (bankWr),
    .bankRd   (bankRd),
    .bankIdx  (bankIdx)
  );

  gpioDatapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .pinLevel    (pinLevel),
    .intPend     (intPend),
    .bankRdData  (bankRdData),
    .pinDriveLow (pinDriveLow),
    .curPage     (curPage),
    .lockMask    (lockMask),
    .rdData      (rdData)
  );

  assign bankPage   = curPage;
  assign bankWrData = wrData;
endmodule

// File: rtl/gpioRegsChecker.sv
module gpioRegsChecker
  import gpioPkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wrEn,
  input logic                   rdEn,
  input logic [BYTE_W-1:0]      wrData,
  input logic [BYTE_W-1:0]      rdData,
  input logic [PIN_W-1:0]       pinLevel,
  input logic [PIN_W-1:0]       pinDriveLow,
  input logic                   bankWr,
  input logic                   bankRd,
  input logic [PAGE_W-1:0]      bankPage,
  input logic [PAGE_W-1:0]      curPage,
  input logic [PORT_COUNT-1:0]  lockMask
);
  localparam int unsigned PLAST = PAGED_BASE + PAGED_COUNT - 1;

  for (genvar k = 0; k < PORT_COUNT; k++) begin : g_portChk
    p_port_load_r2: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && int'(addr) == k && !lockMask[k]) |=> pinDriveLow[k*BYTE_W +: BYTE_W] == $past(wrData));
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && int'(addr) == k && lockMask[k]) |=> $stable(pinDriveLow[k*BYTE_W +: BYTE_W]));
  end

  p_port_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) < PORT_COUNT) |=>
      rdData == ~BYTE_W'($past(pinLevel) >> (int'($past(addr)) * BYTE_W)));

  p_ctrl_reads_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) == CTRL_OFS) |=> rdData == '0);

  p_pend_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) == PEND_OFS) |=> $stable(pinDriveLow));

  p_bank_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) >= PAGED_BASE && int'(addr) <= PLAST && curPage != '0)
      |-> (bankWr && bankPage == curPage));

  p_page0_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (curPage == '0) |-> (!bankWr && !bankRd));

  p_bank_read_page_r9: assert property (@(posedge clk) disable iff (!rstN)
    bankRd |-> (rdEn && curPage == PAGE_W'(PG_ID)));

  p_high_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && int'(addr) > PLAST) |=> rdData == '0);

  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));
endmodule

bind gpio_paged_regfile gpioRegsChecker i_chk (.*);

// File: tb/test_gpio_paged_regfile.sv
`timescale 1ns/1ps
module test_gpio_paged_regfile;
  import gpioPkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                   rstN;
  logic [ADDR_W-1:0]      addr;
  logic                   wrEn, rdEn;
  logic [BYTE_W-1:0]      wrData, rdData;
  logic [PIN_W-1:0]       pinLevel, pinDriveLow;
  logic [PAGED_COUNT-1:0] intPend;
  logic                   bankWr, bankRd;
  logic [PAGE_W-1:0]      bankPage;
  logic [IDX_W-1:0]       bankIdx;
  logic [BYTE_W-1:0]      bankWrData, bankRdData;

  gpio_paged_regfile i_gpio_paged_regfile (.*);

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  logic [7:0] mPort [6];
  logic [1:0] mPage;
  logic [5:0] mLock;
  logic [7:0] mRd;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] mPins();
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[k*8 +: 8] = mPort[k];
    return v;
  endfunction

  // one access cycle: drive at negedge, check strobes, step model, check registered outputs
  task automatic cyc(input logic [3:0] a, input logic w, input logic r, input logic [7:0] d, input string req);
    logic paged;
    logic [7:0] nextRd;
    int ai;
    ai = int'(a);
    addr = a; wrEn = w; rdEn = r; wrData = d;
    #1;
    paged = (ai >= 8) && (ai <= 10);
    chk(req, "bankWr", 64'(bankWr), 64'(w && paged && mPage != 2'd0));
    chk(req, "bankRd", 64'(bankRd), 64'(r && paged && mPage == 2'd3));
    if (w && paged && mPage != 2'd0) begin
      chk(req, "bankPage", 64'(bankPage), 64'(mPage));
      chk(req, "bankIdx", 64'(bankIdx), 64'(ai - 8));
      chk(req, "bankWrData", 64'(bankWrData), 64'(d));
    end
    nextRd = mRd;
    if (r) begin
      if (ai < 6)                      nextRd = ~pinLevel[ai*8 +: 8];
      else if (ai == 6)                nextRd = {5'b0, intPend};
      else if (paged && mPage == 2'd3) nextRd = bankRdData;
      else                             nextRd = 8'h00;
    end
    @(posedge clk);
    mRd = nextRd;
    if (w) begin
      if (ai < 6 && !mLock[ai]) mPort[ai] = d;
      else if (ai == 7) begin
        mPage = d[7:6];
        mLock = d[5:0];
      end
    end
    @(negedge clk);
    chk(req, "pins", 64'(pinDriveLow), 64'(mPins()));
    chk(req, "rdData", 64'(rdData), 64'(mRd));
    wrEn = 1'b0; rdEn = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    nFails++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; addr = '0; wrEn = 0; rdEn = 0; wrData = '0;
    pinLevel = '1; intPend = '0; bankRdData = '0;
    for (int k = 0; k < 6; k++) mPort[k] = '0;
    mPage = '0; mLock = '0; mRd = '0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1", "pins in reset", 64'(pinDriveLow), 64'(0));
    chk("R1", "rdData in reset", 64'(rdData), 64'(0));
    chk("R1", "bankWr in reset", 64'(bankWr), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "pins after reset", 64'(pinDriveLow), 64'(0));
    cyc(4'h9, 1, 0, 8'h11, "R1");           // page 0 after reset: no strobe

    // R2: load each port
    for (int k = 0; k < 6; k++) cyc(4'(k), 1, 0, 8'(8'h31 * (k + 1)), "R2");
    // R3: reads with several pin patterns
    pinLevel = 48'h0123_4567_89AB;
    for (int k = 0; k < 6; k++) cyc(4'(k), 0, 1, 8'h00, "R3");
    pinLevel = 48'hFF00_A55A_0FF0;
    cyc(4'h3, 0, 1, 8'h00, "R3");
    cyc(4'h0, 0, 1, 8'h00, "R3");

    // R4: page/lock register, write-only
    cyc(4'h7, 1, 1, 8'h04, "R4");
    cyc(4'h7, 0, 1, 8'h00, "R4");
    // R5: locked port 2 ignores writes but still reads
    cyc(4'h2, 1, 0, 8'hEE, "R5");
    cyc(4'h2, 0, 1, 8'h00, "R5");
    cyc(4'h1, 1, 0, 8'h5C, "R5");           // neighbour stays writable
    cyc(4'h7, 1, 0, 8'h3F, "R5");           // lock all
    for (int k = 0; k < 6; k++) cyc(4'(k), 1, 0, 8'hA5, "R5");
    cyc(4'h7, 1, 0, 8'h00, "R5");           // unlock
    cyc(4'h2, 1, 0, 8'hEE, "R5");

    // R6: pending summary
    intPend = 3'b101;
    cyc(4'h6, 0, 1, 8'h00, "R6");
    intPend = 3'b010;
    cyc(4'h6, 1, 1, 8'hFF, "R6");

    // R8: page 0 window is dead
    for (int a = 8; a <= 10; a++) cyc(4'(a), 1, 1, 8'h77, "R8");

    // R7 / R9: each nonzero page
    bankRdData = 8'hC3;
    for (int p = 1; p <= 3; p++) begin
      cyc(4'h7, 1, 0, 8'(p << 6), "R7");
      for (int a = 8; a <= 10; a++) begin
        cyc(4'(a), 1, 0, 8'(8'h10 * a + p), "R7");
        bankRdData = 8'(8'h3C + a + p);
        cyc(4'(a), 0, 1, 8'h00, "R9");
      end
    end

    // R10: top offsets
    for (int a = 11; a <= 15; a++) begin
      cyc(4'(a), 1, 0, 8'hFF, "R10");
      cyc(4'(a), 0, 1, 8'h00, "R10");
    end

    // R11: idle cycles keep read data
    cyc(4'h5, 0, 1, 8'h00, "R11");
    pinLevel = ~pinLevel;
    repeat (4) cyc(4'h5, 0, 0, 8'h00, "R11");

    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      pinLevel   = {$urandom, $urandom};
      intPend    = 3'($urandom);
      bankRdData = 8'($urandom);
      cyc(4'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "R2");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule